// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches 16-bit words from a serial EEPROM that uses the three-wire protocol. It drives chip select, shift clock and serial data toward the memory and samples the memory's serial output. The shift clock runs at a fixed half-period, counted in system clocks. A client pulses a start strobe with a word address. When the word has been shifted in, the block returns it together with a one-cycle done strobe.

Coming out of reset, the block runs a boot sequence on its own. First it reads word 0 using an 8-bit address. If that word equals the signature 0x8129, the block keeps 8-bit addressing; for any other value it switches to 6-bit addressing. It then reads words 7, 8 and 9 at the chosen width and assembles them into a 48-bit station address. No client read is accepted until this sequence has finished. Only the read command is ever issued. The write opcode (101) and the erase opcode (111) are never sent.

Top module: `sprom_word_reader`

## Requirements
- R1: From reset until `station_valid` rises, `busy` stays high. The first access after reset reads word 0 with an 8-bit address. `addr_wide` ends at 1 if and only if that word equals 0x8129.
- R2: After word 0, the boot sequence reads words 7, 8 and 9 at the detected width. `station_valid` then rises and stays high. `station_addr` is {word9, word8, word7`}`, so bits [7:0] (the low byte of word 7) are the first address byte. `station_addr` does not change afterwards.
- R3: Each access sends the read opcode 110 and then the word address, MSB first. Exactly 3 + (8 or 6) command bits are clocked. `ee_di` changes only while `ee_sk` is low.
- R4: After the command, 16 data bits are clocked in, MSB first. Each bit is sampled at the end of the clock-high half-period. A client read returns the addressed word on `rd_data`.
- R5: Before each command, `ee_cs` is low for one half-period and then high for one half-period. Chip select is dropped after the 16th data bit and before `rd_done`. `ee_sk` is never high while `ee_cs` is low.
- R6: A `rd_start` while `busy` is high has no effect. This covers both the boot sequence and a client read in progress: no extra `rd_done` is produced, and the running read returns its own word.
- R7: `rd_done` is a one-cycle pulse. In that cycle `busy` is already low, and it was high in the cycle before. A start in that same cycle is accepted.
- R8: Every high phase of `ee_sk` lasts exactly `HALF_CYC` system clocks.
- R9: `rd_data` holds its value except in a cycle where `rd_done` is high.
- R10: With 6-bit addressing, only `rd_addr[5:0]` is sent to the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_start | input | 1 | Start strobe for a client read |
| rd_addr | input | 8 | Word address for a client read |
| rd_data | output | 16 | Last word read by a client read |
| rd_done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | High while booting or while a client read is in progress |
| addr_wide | output | 1 | 1 = 8-bit addressing, 0 = 6-bit addressing |
| station_addr | output | 48 | Station address assembled from words 7 to 9 |
| station_valid | output | 1 | Boot sequence has completed |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The completion of one read and the acceptance of the next can fall in the same cycle. `busy` has already dropped while `rd_done` is high, so a start raised in that cycle must be taken rather than lost. The bench provokes this by watching for `rd_done` and raising `rd_start` with a new address in the same cycle. It judges the outcome in three ways. Exactly two done pulses must appear. The second word must match the new address. The memory model must have seen a fresh chip-select cycle with a correct read opcode.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  localparam int          WORD_W         = 16;
  localparam int          OPC_W          = 3;
  localparam logic [2:0]  OPC_READ       = 3'b110;
  localparam logic [15:0] WIDE_SIGNATURE = 16'h8129;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_CS_LO,
    PH_CS_HI,
    PH_CMD_LO,
    PH_CMD_HI,
    PH_GAP,
    PH_DAT_HI,
    PH_DAT_LO,
    PH_END
  } phase_e;

  typedef enum logic [1:0] {
    SQ_LAUNCH,
    SQ_BOOT_WAIT,
    SQ_READY,
    SQ_USER_WAIT
  } seq_e;

endpackage

// File: rtl/sprom_tick.sv
module sprom_tick #(
  parameter int HALF_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int            CW   = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sprom_engine.sv
module sprom_engine
  import sprom_pkg::*;
#(
  parameter int HALF_CYC  = 50,
  parameter int AW_WIDE   = 8,
  parameter int AW_NARROW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [AW_WIDE-1:0] addr,
  input  logic               wide,
  input  logic               ee_do,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  output logic               done,
  output logic [WORD_W-1:0]  word
);
  localparam int CMD_W = OPC_W + AW_WIDE;
  localparam int PAD_W = AW_WIDE - AW_NARROW;
  localparam int BCW   = $clog2(CMD_W + 1);
  localparam int DCW   = $clog2(WORD_W + 1);

  phase_e             phase_q, phase_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [BCW-1:0]     bits_q, bits_d;
  logic [DCW-1:0]     dcnt_q, dcnt_d;
  logic [WORD_W-1:0]  word_q, word_d;
  logic               cs_q, cs_d, sk_q, sk_d, di_q, di_d, done_q, done_d;
  logic               tick;
  logic [CMD_W-1:0]   wide_cmd, narrow_cmd;

  sprom_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (phase_q != PH_IDLE),
    .tick (tick)
  );

  assign wide_cmd = {OPC_READ, addr};

  // the narrow command is left-aligned so both widths shift out from the top bit
  generate
    if (PAD_W > 0) begin : g_pad
      assign narrow_cmd = {OPC_READ, addr[AW_NARROW-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign narrow_cmd = {OPC_READ, addr};
    end
  endgenerate

  always_comb begin
    phase_d = phase_q;
    cmd_d   = cmd_q;
    bits_d  = bits_q;
    dcnt_d  = dcnt_q;
    word_d  = word_q;
    cs_d    = cs_q;
    sk_d    = sk_q;
    di_d    = di_q;
    done_d  = 1'b0;
    case (phase_q)
      PH_IDLE: if (go) begin
        phase_d = PH_CS_LO;
        cmd_d   = wide ? wide_cmd : narrow_cmd;
        bits_d  = wide ? BCW'(CMD_W) : BCW'(OPC_W + AW_NARROW);
        cs_d    = 1'b0;
        sk_d    = 1'b0;
        di_d    = 1'b0;
      end
      PH_CS_LO: if (tick) begin
        phase_d = PH_CS_HI;
        cs_d    = 1'b1;
      end
      PH_CS_HI: if (tick) begin
        phase_d = PH_CMD_LO;
        di_d    = cmd_q[CMD_W-1];
      end
      PH_CMD_LO: if (tick) begin
        phase_d = PH_CMD_HI;
        sk_d    = 1'b1;
      end
      PH_CMD_HI: if (tick) begin
        sk_d   = 1'b0;
        cmd_d  = cmd_q << 1;
        bits_d = bits_q - 1'b1;
        if (bits_q == BCW'(1)) begin
          phase_d = PH_GAP;
          di_d    = 1'b0;
        end else begin
          phase_d = PH_CMD_LO;
          di_d    = cmd_q[CMD_W-2];
        end
      end
      PH_GAP: if (tick) begin
        phase_d = PH_DAT_HI;
        sk_d    = 1'b1;
        dcnt_d  = DCW'(WORD_W);
      end
      PH_DAT_HI: if (tick) begin
        word_d  = {word_q[WORD_W-2:0], ee_do};
        dcnt_d  = dcnt_q - 1'b1;
        sk_d    = 1'b0;
        phase_d = PH_DAT_LO;
      end
      PH_DAT_LO: if (tick) begin
        if (dcnt_q == '0) begin
          phase_d = PH_END;
          cs_d    = 1'b0;
        end else begin
          phase_d = PH_DAT_HI;
          sk_d    = 1'b1;
        end
      end
      PH_END: if (tick) begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cmd_q   <= '0;
      bits_q  <= '0;
      dcnt_q  <= '0;
      word_q  <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      bits_q  <= bits_d;
      dcnt_q  <= dcnt_d;
      word_q  <= word_d;
      cs_q    <= cs_d;
      sk_q    <= sk_d;
      di_q    <= di_d;
      done_q  <= done_d;
    end
  end

  assign ee_cs = cs_q;
  assign ee_sk = sk_q;
  assign ee_di = di_q;
  assign done  = done_q;
  assign word  = word_q;
endmodule

// File: rtl/sprom_seq.sv
module sprom_seq
  import sprom_pkg::*;
#(
  parameter int AW_WIDE       = 8,
  parameter int STATION_WORD  = 7,
  parameter int STATION_WORDS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_start,
  input  logic [AW_WIDE-1:0]              rd_addr,
  input  logic                            eng_done,
  input  logic [WORD_W-1:0]               eng_word,
  output logic                            go,
  output logic [AW_WIDE-1:0]              go_addr,
  output logic                            wide,
  output logic                            busy,
  output logic                            rd_done,
  output logic [WORD_W-1:0]               rd_data,
  output logic [STATION_WORDS*WORD_W-1:0] station_addr,
  output logic                            station_valid
);
  localparam int ST_W = STATION_WORDS * WORD_W;
  localparam int IW   = $clog2(STATION_WORDS + 1);

  seq_e              st_q, st_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              wide_q, wide_d, busy_q, busy_d, done_q, done_d, valid_q, valid_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [ST_W-1:0]   stat_q, stat_d;
  logic [AW_WIDE-1:0] boot_addr;

  // boot step 0 fetches word 0, steps 1..N fetch the station words
  assign boot_addr = (idx_q == '0) ? '0 : AW_WIDE'(STATION_WORD - 1 + int'(idx_q));
  assign go        = (st_q == SQ_LAUNCH) || ((st_q == SQ_READY) && rd_start);
  assign go_addr   = (st_q == SQ_READY) ? rd_addr : boot_addr;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    wide_d  = wide_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    valid_d = valid_q;
    data_d  = data_q;
    stat_d  = stat_q;
    case (st_q)
      SQ_LAUNCH: st_d = SQ_BOOT_WAIT;
      SQ_BOOT_WAIT: if (eng_done) begin
        if (idx_q == '0) wide_d = (eng_word == WIDE_SIGNATURE);
        for (int k = 0; k < STATION_WORDS; k++) begin
          if (int'(idx_q) == k + 1) stat_d[k*WORD_W +: WORD_W] = eng_word;
        end
        if (int'(idx_q) == STATION_WORDS) begin
          st_d    = SQ_READY;
          busy_d  = 1'b0;
          valid_d = 1'b1;
        end else begin
          st_d  = SQ_LAUNCH;
          idx_d = idx_q + 1'b1;
        end
      end
      SQ_READY: if (rd_start) begin
        st_d   = SQ_USER_WAIT;
        busy_d = 1'b1;
      end
      SQ_USER_WAIT: if (eng_done) begin
        data_d = eng_word;
        done_d = 1'b1;
        busy_d = 1'b0;
        st_d   = SQ_READY;
      end
      default: st_d = SQ_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_LAUNCH;
      idx_q   <= '0;
      wide_q  <= 1'b1;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      stat_q  <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      wide_q  <= wide_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      stat_q  <= stat_d;
    end
  end

  assign wide          = wide_q;
  assign busy          = busy_q;
  assign rd_done       = done_q;
  assign rd_data       = data_q;
  assign station_addr  = stat_q;
  assign station_valid = valid_q;
endmodule

// File: rtl/sprom_word_reader.sv
module sprom_word_reader
  import sprom_pkg::*;
#(
  parameter int HALF_CYC      = 50,
  parameter int AW_WIDE       = 8,
  parameter int AW_NARROW     = 6,
  parameter int STATION_WORD  = 7,
  parameter int STATION_WORDS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_start,
  input  logic [AW_WIDE-1:0]              rd_addr,
  output logic [WORD_W-1:0]               rd_data,
  output logic                            rd_done,
  output logic                            busy,
  output logic                            addr_wide,
  output logic [STATION_WORDS*WORD_W-1:0] station_addr,
  output logic                            station_valid,
  output logic                            ee_cs,
  output logic                            ee_sk,
  output logic                            ee_di,
  input  logic                            ee_do
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               go, eng_done;
  logic [AW_WIDE-1:0] go_addr;
  logic [WORD_W-1:0]  eng_word;

  // the reset asserts at once and releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sprom_seq #(
    .AW_WIDE      (AW_WIDE),
    .STATION_WORD (STATION_WORD),
    .STATION_WORDS(STATION_WORDS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .rd_start     (rd_start),
    .rd_addr      (rd_addr),
    .eng_done     (eng_done),
    .eng_word     (eng_word),
    .go           (go),
    .go_addr      (go_addr),
    .wide         (addr_wide),
    .busy         (busy),
    .rd_done      (rd_done),
    .rd_data      (rd_data),
    .station_addr (station_addr),
    .station_valid(station_valid)
  );

  sprom_engine #(
    .HALF_CYC (HALF_CYC),
    .AW_WIDE  (AW_WIDE),
    .AW_NARROW(AW_NARROW)
  ) u_eng (
    .clk  (clk),
    .rst_n(rst_int_n),
    .go   (go),
    .addr (go_addr),
    .wide (addr_wide),
    .ee_do(ee_do),
    .ee_cs(ee_cs),
    .ee_sk(ee_sk),
    .ee_di(ee_di),
    .done (eng_done),
    .word (eng_word)
  );
endmodule

// File: rtl/sprom_word_reader_chk.sv
module sprom_word_reader_chk #(
  parameter int HALF_CYC = 50,
  parameter int ST_W     = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ee_cs,
  input logic            ee_sk,
  input logic            ee_di,
  input logic            rd_done,
  input logic            busy,
  input logic [15:0]     rd_data,
  input logic            station_valid,
  input logic [ST_W-1:0] station_addr
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_cnt <= '0;
    else if (ee_sk) hi_cnt <= hi_cnt + 1'b1;
    else            hi_cnt <= '0;
  end

  assert_boot_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !station_valid |-> busy);

  assert_station_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    station_valid |=> (station_valid && $stable(station_addr)));

  assert_di_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  assert_sk_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);

  assert_cs_low_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !ee_cs);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (!busy && $past(busy)));

  assert_half_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_sk && $past(ee_sk)) |-> (hi_cnt == 32'(HALF_CYC)));

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |-> $stable(rd_data));
endmodule

bind sprom_word_reader sprom_word_reader_chk #(
  .HALF_CYC(HALF_CYC),
  .ST_W    (STATION_WORDS * 16)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ee_cs        (ee_cs),
  .ee_sk        (ee_sk),
  .ee_di        (ee_di),
  .rd_done      (rd_done),
  .busy         (busy),
  .rd_data      (rd_data),
  .station_valid(station_valid),
  .station_addr (station_addr)
);

// File: tb/sim_sprom_word_reader.sv
module sim_sprom_word_reader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic        clk, rst_n, rd_start, rd_done, busy, addr_wide, station_valid;
  logic        ee_cs, ee_sk, ee_di, ee_do;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic [47:0] station_addr;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int cs_rise = 0;
  int cyc = 0;
  bit finished = 0;

  // memory model state
  logic [15:0] m_mem [0:255];
  int          m_aw = 8;
  int          m_cnt = 0;
  bit          m_data = 0;
  int          m_idx = 0;
  int          m_addr = 0;
  int          m_bad = 0;
  int          m_last = -1;
  logic [10:0] m_cmd = '0;
  logic        m_do = 1'b0;

  int run_cnt = 0;
  int last_run = 0;

  sprom_word_reader #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_done(rd_done), .busy(busy), .addr_wide(addr_wide),
    .station_addr(station_addr), .station_valid(station_valid),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  assign ee_do = m_do;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      m_cnt  = 0;
      m_data = 0;
      m_do   = 1'b0;
    end else if (!m_data) begin
      m_cmd = {m_cmd[9:0], ee_di};
      m_cnt++;
      if (m_cnt == 3 + m_aw) begin
        m_data = 1;
        m_idx  = 15;
        m_addr = int'(m_cmd) & ((1 << m_aw) - 1);
        m_last = m_addr;
        if (((int'(m_cmd) >> m_aw) & 7) != 6) m_bad++;
      end
    end else begin
      m_do = (m_idx >= 0) ? m_mem[m_addr][m_idx] : 1'b0;
      m_idx--;
    end
  end

  always @(posedge ee_cs) cs_rise++;

  always @(posedge clk) if (rst_n && rd_done) done_cnt++;

  always @(negedge clk) begin
    if (ee_sk) run_cnt++;
    else begin
      if (run_cnt != 0) last_run = run_cnt;
      run_cnt = 0;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic fill_mem(input int aw, input logic [15:0] w0);
    for (int i = 0; i < 256; i++) m_mem[i] = 16'((i * 16'h0301 + 16'h1C0F) & 16'hFFFF);
    m_mem[0] = w0;
    m_aw = aw;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (rd_done !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) chk({tag, " timeout"}, 0, 1);
  endtask

  task automatic pulse_start(input logic [7:0] a);
    @(negedge clk);
    rd_start = 1'b1;
    rd_addr  = a;
    @(negedge clk);
    rd_start = 1'b0;
  endtask

  // R1 R5: values held under reset
  task automatic t_reset_state(input int aw, input logic [15:0] w0);
    rst_n = 1'b0;
    fill_mem(aw, w0);
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", busy, 1);
    chk("R2 valid in reset", station_valid, 0);
    chk("R5 cs in reset", ee_cs, 0);
    chk("R5 sk in reset", ee_sk, 0);
    chk("R7 done in reset", rd_done, 0);
    rst_n = 1'b1;
  endtask

  // R1 R2 R6: boot sequence, with a start pulse that must be ignored
  task automatic t_boot(input logic exp_wide, input bit chk_station);
    int n = 0;
    int d0 = done_cnt;
    int b0 = m_bad;
    pulse_start(8'h21);
    while (station_valid !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R1 boot ends", station_valid, 1);
    chk("R1 width detect", addr_wide, exp_wide);
    chk("R1 busy after boot", busy, 0);
    chk("R6 start during boot ignored", done_cnt - d0, 0);
    chk("R3 opcode during boot", m_bad - b0, 0);
    if (chk_station)
      chk("R2 station address", station_addr, {m_mem[9], m_mem[8], m_mem[7]});
    repeat (3 * HALF) @(negedge clk);
    chk("R2 station held", station_addr, chk_station ? {m_mem[9], m_mem[8], m_mem[7]} : station_addr);
  endtask

  // R4 R5 R8 R10: single client read
  task automatic t_user_read(input logic [7:0] a);
    int exp_idx = (m_aw == 8) ? int'(a) : int'(a[5:0]);
    int d0 = done_cnt;
    int c0 = cs_rise;
    int b0 = m_bad;
    pulse_start(a);
    chk("R6 busy after start", busy, 1);
    wait_done("R4 read");
    chk("R7 busy low at done", busy, 0);
    chk("R5 cs low at done", ee_cs, 0);
    chk("R4 read data", rd_data, m_mem[exp_idx]);
    chk("R10 address seen by memory", m_last, exp_idx);
    chk("R3 opcode", m_bad - b0, 0);
    chk("R5 one select cycle", cs_rise - c0, 1);
    @(negedge clk);
    chk("R7 done one cycle", rd_done, 0);
    chk("R8 clock high length", last_run, HALF);
    chk("R7 done count", done_cnt - d0, 1);
  endtask

  // R6: start during a client read
  task automatic t_ignore_busy();
    int d0 = done_cnt;
    pulse_start(8'h44);
    repeat (5 * HALF) @(negedge clk);
    rd_start = 1'b1;
    rd_addr  = 8'h55;
    @(negedge clk);
    rd_start = 1'b0;
    wait_done("R6 read");
    chk("R6 first word kept", rd_data, m_mem[8'h44]);
    repeat (300) @(negedge clk);
    chk("R6 no second done", done_cnt - d0, 1);
    chk("R9 data held", rd_data, m_mem[8'h44]);
  endtask

  // R7: start in the cycle of rd_done
  task automatic t_back_to_back();
    int d0 = done_cnt;
    pulse_start(8'h12);
    wait_done("R7 first");
    chk("R7 first word", rd_data, m_mem[8'h12]);
    rd_start = 1'b1;
    rd_addr  = 8'hE7;
    @(negedge clk);
    rd_start = 1'b0;
    chk("R7 start taken at done", busy, 1);
    wait_done("R7 second");
    chk("R7 second word", rd_data, m_mem[8'hE7]);
    @(negedge clk);
    chk("R7 two dones", done_cnt - d0, 2);
  endtask

  initial begin
    rst_n    = 1'b0;
    rd_start = 1'b0;
    rd_addr  = '0;
    // wide device carrying the signature
    t_reset_state(8, 16'h8129);
    t_boot(1'b1, 1);
    t_user_read(8'hC5);
    t_user_read(8'h3A);
    t_user_read(8'hFF);
    t_ignore_busy();
    t_back_to_back();
    // narrow device: an 8-bit probe of word 0 reads shifted data, so 6-bit addressing
    t_reset_state(6, 16'h1234);
    t_boot(1'b0, 1);
    t_user_read(8'hC5);
    t_user_read(8'h3F);
    // wide-style device lacking the signature
    t_reset_state(8, 16'h8128);
    t_boot(1'b0, 0);
    summary();
  end
endmodule